// File: doc/BRIEF.md
# Maskable Interrupt Controller with Per-Source Normal/Fast Routing

This block gathers up to 64 level-sensitive interrupt sources and drives two processor request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Every source has an enable bit and a routing bit. Sources 0 to 31 form the lower bank and sources 32 to 63 form the upper bank. Each bank has its own enable register and its own routing register.

Software uses a simple synchronous register port. Writes are taken on the clock edge and reads are combinational. Software can read back the enable and routing registers, the per-bank status words for each request line, and a vector word. The vector word gives the lowest-numbered source that currently drives the normal request. The upper bank can be left out through a parameter. A source is silenced by clearing its enable bit, because the block has no latch that software would need to clear.

Top module: `irq_fiq_router`

## Requirements
- R1: After reset, every enable and routing register reads 0, so all sources are disabled and routed to the normal request. `irq_o` and `fiq_o` are low.
- R2: An enable bit of 1 lets its source through and an enable bit of 0 blocks it. With all enable bits at 0, neither request line is asserted, whatever the source levels.
- R3: A routing bit of 0 sends an enabled source to `irq_o` and a routing bit of 1 sends it to `fiq_o`.
- R4: `irq_o` is high exactly when some source is high, enabled and routed to normal. `fiq_o` is high exactly when some source is high, enabled and routed to fast.
- R5: Source n with n ≥ 32 is governed by bit n−32 of the upper enable register (address 2) and the upper routing register (address 3). The lower registers are at address 0 (enable) and address 1 (routing).
- R6: The status words are read-only: address 4 gives the lower normal status, 5 the lower fast status, 6 the upper normal status and 7 the upper fast status. Each reads source & enable & (routing equals the line's code). A write to these addresses changes nothing.
- R7: Address 8 reads the lowest-numbered source that is driving `irq_o`, plus one, or 0 when none is.
- R8: With `HAS_UPPER`=0, the upper registers and status words read 0, writes to them are dropped, and sources 32–63 never raise either request line.
- R9: A write to address 0, 1, 2 or 3 stores `wdata_i`, which reads back from the same address in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Level interrupt sources |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check four things on every cycle. Nothing reaches either request line while the lower enables are clear and the upper bank is idle. A fully fast-routed lower bank never raises `irq_o` on its own account. The vector word is zero exactly when `irq_o` is low. A status word never shows a disabled source. An assertion also checks that register writes land in the following cycle.

The bench scenarios cover what the assertions cannot: the split of mixed masks and routes between the two lines, the lowest-index choice across both banks, the placement of upper-bank bits, the read-only status words, and the reduced build with no upper bank.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_LO  = 4'd0,
    A_ROUTE_LO = 4'd1,
    A_MASK_HI  = 4'd2,
    A_ROUTE_HI = 4'd3,
    A_IRQ_LO   = 4'd4,
    A_FIQ_LO   = 4'd5,
    A_IRQ_HI   = 4'd6,
    A_FIQ_HI   = 4'd7,
    A_VEC      = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         mask_we_i,
  input  logic         route_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] route_o,
  output logic [W-1:0] irq_stat_o,
  output logic [W-1:0] fiq_stat_o
);
  logic [W-1:0] mask_q, route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (mask_we_i)  mask_q  <= wdata_i;
      if (route_we_i) route_q <= wdata_i;
    end
  end

  assign mask_o     = mask_q;
  assign route_o    = route_q;
  assign irq_stat_o = src_i & mask_q & ~route_q;
  assign fiq_stat_o = src_i & mask_q & route_q;
endmodule

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int N  = 64,
  localparam int VW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [VW-1:0] vec_o
);
  // scan high to low so the lowest index wins
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VW'(i + 1);
    end
  end
endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
  import intc_pkg::*;
#(
  parameter bit HAS_UPPER = 1'b1,
  localparam int NSRC = 2 * BANK_W,
  localparam int VW   = $clog2(NSRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [1:0][BANK_W-1:0] mask_w, route_w, irq_stat_w, fiq_stat_w;
  logic [VW-1:0]          vec_w;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] MASK_A  = (b == 0) ? A_MASK_LO  : A_MASK_HI;
    localparam logic [ADDR_W-1:0] ROUTE_A = (b == 0) ? A_ROUTE_LO : A_ROUTE_HI;
    if (b == 0 || HAS_UPPER) begin : g_on
      intc_bank #(.W(BANK_W)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i[b*BANK_W +: BANK_W]),
        .mask_we_i  (we_i && addr_i == MASK_A),
        .route_we_i (we_i && addr_i == ROUTE_A),
        .wdata_i    (wdata_i),
        .mask_o     (mask_w[b]),
        .route_o    (route_w[b]),
        .irq_stat_o (irq_stat_w[b]),
        .fiq_stat_o (fiq_stat_w[b])
      );
    end else begin : g_off
      assign mask_w[b]     = '0;
      assign route_w[b]    = '0;
      assign irq_stat_w[b] = '0;
      assign fiq_stat_w[b] = '0;
    end
  end

  intc_vec #(.N(NSRC)) u_vec (
    .req_i (irq_stat_w),
    .vec_o (vec_w)
  );

  assign irq_o = |irq_stat_w;
  assign fiq_o = |fiq_stat_w;

  always_comb begin
    unique case (addr_i)
      A_MASK_LO:  rdata_o = mask_w[0];
      A_ROUTE_LO: rdata_o = route_w[0];
      A_MASK_HI:  rdata_o = mask_w[1];
      A_ROUTE_HI: rdata_o = route_w[1];
      A_IRQ_LO:   rdata_o = irq_stat_w[0];
      A_FIQ_LO:   rdata_o = fiq_stat_w[0];
      A_IRQ_HI:   rdata_o = irq_stat_w[1];
      A_FIQ_HI:   rdata_o = fiq_stat_w[1];
      A_VEC:      rdata_o = BANK_W'(vec_w);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_fiq_router_chk.sv
module irq_fiq_router_chk
  import intc_pkg::*;
#(
  parameter int VW = 7
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [BANK_W-1:0]      wdata_i,
  input logic                   irq_o,
  input logic                   fiq_o,
  input logic [VW-1:0]          vec_w,
  input logic [1:0][BANK_W-1:0] mask_w,
  input logic [1:0][BANK_W-1:0] route_w,
  input logic [1:0][BANK_W-1:0] irq_stat_w,
  input logic [1:0][BANK_W-1:0] fiq_stat_w
);
  // R2
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w[0] == '0 && mask_w[1] == '0) |-> (!irq_o && !fiq_o));

  // R3
  fast_route_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_w[0] == '1 && irq_stat_w[1] == '0) |-> !irq_o);

  // R7
  vec_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_w == '0) == !irq_o);

  // R6
  stat_within_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_stat_w[0] | fiq_stat_w[0]) & ~mask_w[0]) == '0);

  // R9
  mask_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK_LO) |=> (mask_w[0] == $past(wdata_i)));
endmodule

bind irq_fiq_router irq_fiq_router_chk #(.VW(VW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .vec_w      (vec_w),
  .mask_w     (mask_w),
  .route_w    (route_w),
  .irq_stat_w (irq_stat_w),
  .fiq_stat_w (fiq_stat_w)
);

// File: tb/irq_fiq_router_tb_top.sv
module irq_fiq_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, rdata_lo;
  logic        irq_o, fiq_o, irq_lo, fiq_lo;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk_i = ~clk_i;

  irq_fiq_router dut_i (
    .clk_i, .rst_ni, .src_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .fiq_o
  );

  irq_fiq_router #(.HAS_UPPER(1'b0)) dut_lo_i (
    .clk_i, .rst_ni, .src_i, .we_i, .addr_i, .wdata_i,
    .rdata_o(rdata_lo), .irq_o(irq_lo), .fiq_o(fiq_lo)
  );

  // mask, route, src, irq, fiq, vec
  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] route;
    logic [31:0] src;
    logic        irq;
    logic        fiq;
    logic [6:0]  vec;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TABLE [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 7'd0},
    '{32'h0000_0002, 32'h0000_0000, 32'h0000_0012, 1'b1, 1'b0, 7'd2},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 1'b1, 7'd0},
    '{32'hF0F0_F0F0, 32'h0F0F_0000, 32'h0000_FF00, 1'b1, 1'b0, 7'd13},
    '{32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, 7'd32},
    '{32'h0000_0003, 32'h0000_0001, 32'h0000_0003, 1'b1, 1'b1, 7'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), d); chk("R1 reg", d, 32'h0);
    end
    src_i = '1; #1;
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 fiq", 32'(fiq_o), 32'h0);

    // table walk: lower bank, upper idle (R2 R3 R4 R6 R7)
    src_i = '0;
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, TABLE[i].mask);
      wr(4'd1, TABLE[i].route);
      src_i = {32'h0, TABLE[i].src};
      #1;
      chk($sformatf("R4 irq v%0d", i), 32'(irq_o), 32'(TABLE[i].irq));
      chk($sformatf("R3 fiq v%0d", i), 32'(fiq_o), 32'(TABLE[i].fiq));
      rd(4'd8, d); chk($sformatf("R7 vec v%0d", i), d, 32'(TABLE[i].vec));
      rd(4'd4, d); chk($sformatf("R6 irq_stat v%0d", i), d,
                       TABLE[i].src & TABLE[i].mask & ~TABLE[i].route);
      rd(4'd5, d); chk($sformatf("R6 fiq_stat v%0d", i), d,
                       TABLE[i].src & TABLE[i].mask & TABLE[i].route);
      // R9 readback
      rd(4'd0, d); chk("R9 mask_lo", d, TABLE[i].mask);
      rd(4'd1, d); chk("R9 route_lo", d, TABLE[i].route);
    end

    // R5 upper bank placement: source 37 -> bit 5
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    wr(4'd0, 32'h0000_0020);            // lower bit 5 must not enable source 37
    src_i = 64'h0000_0020_0000_0000; #1;
    chk("R5 lower mask no upper", 32'(irq_o), 32'h0);
    wr(4'd2, 32'h0000_0020);
    #1; chk("R5 upper irq", 32'(irq_o), 32'h1);
    rd(4'd8, d); chk("R5 vec 38", d, 32'd38);
    rd(4'd6, d); chk("R5 irq_stat_hi", d, 32'h0000_0020);
    rd(4'd2, d); chk("R9 mask_hi", d, 32'h0000_0020);
    // R7 lowest index across banks
    wr(4'd0, 32'h0000_0028);
    src_i[3] = 1'b1; #1;
    rd(4'd8, d); chk("R7 lowest across banks", d, 32'd4);
    src_i[3] = 1'b0;
    wr(4'd3, 32'h0000_0020);
    #1;
    chk("R5 upper fiq", 32'(fiq_o), 32'h1);
    chk("R3 upper off irq", 32'(irq_o), 32'h0);
    rd(4'd7, d); chk("R5 fiq_stat_hi", d, 32'h0000_0020);
    rd(4'd3, d); chk("R9 route_hi", d, 32'h0000_0020);

    // R6 status write ignored
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd7, 32'h0);
    rd(4'd7, d); chk("R6 status ro", d, 32'h0000_0020);
    rd(4'd0, d); chk("R6 mask untouched", d, 32'h0000_0028);

    // R8 reduced build
    src_i = {32'hFFFF_FFFF, 32'h0};
    wr(4'd2, 32'hFFFF_FFFF);
    addr_i = 4'd2; #1; chk("R8 mask_hi zero", rdata_lo, 32'h0);
    addr_i = 4'd6; #1; chk("R8 stat_hi zero", rdata_lo, 32'h0);
    chk("R8 no irq", 32'(irq_lo), 32'h0);
    chk("R8 no fiq", 32'(fiq_lo), 32'h0);

    finish_run();
  end
endmodule